// File: doc/BRIEF.md
# Page-Triggered Access Logger

This block sits between a network-facing request stream and memory. Remote puts and gets arrive there. Each request's address selects a page, and the block reads that page's attribute bits through a lookup port. The attribute bits are write permission, write logging, write-data logging, read logging, read-data logging and a log selector. A write to a page that does not permit writes leaves memory untouched. If write logging is enabled for that page, the write becomes a record in the log that the page selects. If it is not enabled, the write is reported as a fault. A read always goes to memory, and the read-logging bits can also record it.

Every log is a private circular buffer held inside the block. Software reads a log from its oldest entry onward and retires records one at a time. Each log has its own level interrupt. The first record appended raises it, and retiring a record clears it. A request that needs a record but targets a full log is held with backpressure and is not lost. Requests that need no record, or that target another log, keep flowing.

Top module: `page_access_logger`

## Requirements
- R1: A write to a page with write permission set drives `mem_we` with the request's address and data one cycle after acceptance. It reports completion code 0 (pass) and adds no record, whatever the logging bits are.
- R2: A write to a page without write permission never asserts `mem_we`. If write logging is clear, it completes with code 2 (fault) and adds no record.
- R3: A write to a page without write permission and with write logging set appends one record to the log named by `attr_log_id` and completes with code 1. The record holds the full request address, and bit 1 of its flags (read) is 0.
- R4: In a logged write, flag bit 0 (data kept) equals the page's write-data-logging bit. The record's data field holds the write data when that bit is set and zero when it is clear.
- R5: A read always pulses `mem_re` one cycle after acceptance. With read logging clear it completes with code 0 and adds no record. With read logging set it completes with code 3 and appends a record whose flag bit 1 is 1. That record's flag bit 0 and data field follow the read-data-logging bit, in the same way R4 describes for writes.
- R6: A record goes only to the log its page selects. The other logs keep their count, contents and interrupt.
- R7: Each log is a FIFO of `DEPTH` records. Read offset 0 on `sw_rd_idx` is the oldest record. A pop of the log on `sw_log_sel` removes the oldest record, and order is kept across pointer wrap-around.
- R8: While the target log holds `DEPTH` records, a request that would append to it sees `req_ready` low and produces no completion. Requests that need no record, or that go to another log, stay ready. After a pop, the held request is accepted.
- R9: `irq[i]` rises the cycle after a record is appended to log i. A pop of a non-empty log i clears it the cycle after, unless a record is appended to log i in that same cycle.
- R10: After reset every log is empty, `irq` is 0, `cpl_valid` is 0 and `req_ready` is 1. A pop of an empty log changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_write | input | 1 | 1 for a write (put), 0 for a read (get) |
| req_addr | input | AW | Request byte address |
| req_data | input | DW | Write data, or the read request's payload word |
| attr_page | output | AW-PAGE_BITS | Page number sent to the attribute lookup |
| attr_wperm | input | 1 | Page allows writes |
| attr_wlog | input | 1 | Log suppressed writes |
| attr_wlogdata | input | 1 | Keep write data in the record |
| attr_rlog | input | 1 | Log reads |
| attr_rlogdata | input | 1 | Keep read payload in the record |
| attr_log_id | input | LW | Log selected by the page |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| cpl_valid | output | 1 | Completion strobe |
| cpl_code | output | 2 | 0 pass, 1 write logged, 2 write fault, 3 read logged |
| cpl_addr | output | AW | Address of the completed request |
| sw_pop | input | 1 | Retire the oldest record of the selected log |
| sw_log_sel | input | LW | Log selected for software read and pop |
| sw_rd_idx | input | IW | Offset from the oldest record |
| sw_count | output | CW | Record count of the selected log |
| sw_rec_addr | output | AW | Address field of the addressed record |
| sw_rec_data | output | DW | Data field of the addressed record |
| sw_rec_flags | output | 2 | Bit 1 read, bit 0 data kept |
| irq | output | NLOGS | Per-log interrupt, level |

## Verification
A wrong decision in the classifier shows up at the completion port and on the memory strobes one cycle after acceptance. It also shows up as a count or record that does not match on the software read port in that same cycle. Corrupt ring pointers show first as a record read in the wrong order, or as stale data after the first wrap-around, which happens on the fifth append to a log of four entries. A wrong full flag shows at once: `req_ready` stays low when it should be high, or a completion appears while the log is full. A wrong interrupt flag is visible one cycle after the append or pop that should have moved it.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    CPL_PASS  = 2'd0,
    CPL_WLOG  = 2'd1,
    CPL_FAULT = 2'd2,
    CPL_RLOG  = 2'd3
  } cpl_code_e;

  typedef struct packed {
    logic      mem_wr;
    logic      mem_rd;
    logic      rec;
    logic      keep;
    logic      is_rd;
    cpl_code_e code;
  } pal_action_t;

  // Decision table: what a request does given its page attributes.
  function automatic pal_action_t decide(input logic wr, input logic w,
                                         input logic wl, input logic wld,
                                         input logic rl, input logic rld);
    pal_action_t a;
    a = '0;
    a.code = CPL_PASS;
    if (wr) begin
      if (w) begin
        a.mem_wr = 1'b1;
      end else if (wl) begin
        a.rec  = 1'b1;
        a.keep = wld;
        a.code = CPL_WLOG;
      end else begin
        a.code = CPL_FAULT;
      end
    end else begin
      a.mem_rd = 1'b1;
      a.is_rd  = 1'b1;
      if (rl) begin
        a.rec  = 1'b1;
        a.keep = rld;
        a.code = CPL_RLOG;
      end
    end
    return a;
  endfunction

  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ring_slot(input int unsigned base, input int unsigned off,
                                            input int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/pal_classify.sv
module pal_classify
  import pal_pkg::*;
(
  input  logic        wr,
  input  logic        w,
  input  logic        wl,
  input  logic        wld,
  input  logic        rl,
  input  logic        rld,
  output pal_action_t act
);
  always_comb act = decide(wr, w, wl, wld, rl, rld);
endmodule

// File: rtl/pal_log_ring.sv
module pal_log_ring
  import pal_pkg::*;
#(
  parameter int REC_W = 50,
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [REC_W-1:0] push_rec,
  input  logic             pop_req,
  input  logic [IW-1:0]    rd_off,
  output logic [REC_W-1:0] rd_rec,
  output logic [CW-1:0]    count,
  output logic             full
);
  logic [REC_W-1:0] slots [DEPTH];
  logic [IW-1:0]    head, tail;
  logic             push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop_req && (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) slots[head] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push_ok) head <= IW'(ring_next(32'(head), DEPTH));
      if (pop_ok)  tail <= IW'(ring_next(32'(tail), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_rec = slots[IW'(ring_slot(32'(tail), 32'(rd_off), DEPTH))];

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count == '0 && !push) |=> count == '0);
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop_req) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/pal_irq_flag.sv
module pal_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)     irq <= 1'b0;
    else if (set)   irq <= 1'b1;
    else if (clear) irq <= 1'b0;
  end

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set));
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !set) |=> !irq);
endmodule

// File: rtl/page_access_logger.sv
module page_access_logger
  import pal_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int PAGE_BITS = 8,
  parameter int NLOGS     = 2,
  parameter int DEPTH     = 4,
  localparam int LW    = (NLOGS > 1) ? $clog2(NLOGS) : 1,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = AW - PAGE_BITS,
  localparam int REC_W = 2 + AW + DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  output logic [PW-1:0]    attr_page,
  input  logic             attr_wperm,
  input  logic             attr_wlog,
  input  logic             attr_wlogdata,
  input  logic             attr_rlog,
  input  logic             attr_rlogdata,
  input  logic [LW-1:0]    attr_log_id,
  output logic             mem_we,
  output logic             mem_re,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             cpl_valid,
  output logic [1:0]       cpl_code,
  output logic [AW-1:0]    cpl_addr,
  input  logic             sw_pop,
  input  logic [LW-1:0]    sw_log_sel,
  input  logic [IW-1:0]    sw_rd_idx,
  output logic [CW-1:0]    sw_count,
  output logic [AW-1:0]    sw_rec_addr,
  output logic [DW-1:0]    sw_rec_data,
  output logic [1:0]       sw_rec_flags,
  output logic [NLOGS-1:0] irq
);
  pal_action_t      act;
  logic             acc, full_sel;
  logic [REC_W-1:0] new_rec;
  logic [NLOGS-1:0] push_v, pop_v, full_v, popped_v;
  logic [REC_W-1:0] rd_v  [NLOGS];
  logic [CW-1:0]    cnt_v [NLOGS];
  logic [REC_W-1:0] sel_rec;

  assign attr_page = req_addr[AW-1:PAGE_BITS];

  pal_classify u_cls (
    .wr (req_write), .w (attr_wperm), .wl (attr_wlog), .wld (attr_wlogdata),
    .rl (attr_rlog), .rld (attr_rlogdata), .act (act)
  );

  always_comb begin
    full_sel = 1'b0;
    for (int i = 0; i < NLOGS; i++)
      if (attr_log_id == LW'(i)) full_sel = full_v[i];
  end

  assign req_ready = !(act.rec && full_sel);
  assign acc       = req_valid && req_ready;
  assign new_rec   = {act.is_rd, act.keep, req_addr, act.keep ? req_data : '0};

  generate
    for (genvar g = 0; g < NLOGS; g++) begin : g_log
      assign push_v[g]   = acc && act.rec && (attr_log_id == LW'(g));
      assign pop_v[g]    = sw_pop && (sw_log_sel == LW'(g));
      assign popped_v[g] = pop_v[g] && (cnt_v[g] != '0);

      pal_log_ring #(.REC_W(REC_W), .DEPTH(DEPTH)) u_ring (
        .clk (clk), .rst_n (rst_n), .push (push_v[g]), .push_rec (new_rec),
        .pop_req (pop_v[g]), .rd_off (sw_rd_idx), .rd_rec (rd_v[g]),
        .count (cnt_v[g]), .full (full_v[g])
      );

      pal_irq_flag u_irq (
        .clk (clk), .rst_n (rst_n), .set (push_v[g]), .clear (popped_v[g]),
        .irq (irq[g])
      );
    end
  endgenerate

  always_comb begin
    sel_rec  = '0;
    sw_count = '0;
    for (int i = 0; i < NLOGS; i++)
      if (sw_log_sel == LW'(i)) begin
        sel_rec  = rd_v[i];
        sw_count = cnt_v[i];
      end
  end

  assign sw_rec_flags = sel_rec[REC_W-1 -: 2];
  assign sw_rec_addr  = sel_rec[DW +: AW];
  assign sw_rec_data  = sel_rec[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cpl_valid <= 1'b0;
      cpl_code  <= 2'(CPL_PASS);
      cpl_addr  <= '0;
    end else begin
      mem_we    <= acc && act.mem_wr;
      mem_re    <= acc && act.mem_rd;
      cpl_valid <= acc;
      if (acc) begin
        mem_addr  <= req_addr;
        mem_wdata <= req_data;
        cpl_code  <= 2'(act.code);
        cpl_addr  <= req_addr;
      end
    end
  end

  // R2
  wprot_no_mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !attr_wperm) |=> (!mem_we && cpl_code != 2'(CPL_PASS)));
  // R1
  pass_has_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_code == 2'(CPL_PASS)) |-> (mem_we || mem_re));
  // R6
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push_v));
  // R8
  stall_no_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !cpl_valid);
endmodule

// File: tb/page_access_logger_tb.sv
`timescale 1ns/1ps
module page_access_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_data;
  logic [7:0]  attr_page;
  logic        attr_wperm, attr_wlog, attr_wlogdata, attr_rlog, attr_rlogdata;
  logic [0:0]  attr_log_id;
  logic        mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        cpl_valid;
  logic [1:0]  cpl_code;
  logic [15:0] cpl_addr;
  logic        sw_pop;
  logic [0:0]  sw_log_sel;
  logic [1:0]  sw_rd_idx;
  logic [2:0]  sw_count;
  logic [15:0] sw_rec_addr;
  logic [31:0] sw_rec_data;
  logic [1:0]  sw_rec_flags;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;

  // Page table: page bit0 W, bit1 WL, bit2 WLD, bit3 RL, bit4 RLD, bit5 log id.
  assign attr_wperm    = attr_page[0];
  assign attr_wlog     = attr_page[1];
  assign attr_wlogdata = attr_page[2];
  assign attr_rlog     = attr_page[3];
  assign attr_rlogdata = attr_page[4];
  assign attr_log_id   = attr_page[5];

  always #2.5 clk = ~clk;

  page_access_logger u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_data,
    .attr_page, .attr_wperm, .attr_wlog, .attr_wlogdata, .attr_rlog,
    .attr_rlogdata, .attr_log_id, .mem_we, .mem_re, .mem_addr, .mem_wdata,
    .cpl_valid, .cpl_code, .cpl_addr, .sw_pop, .sw_log_sel, .sw_rd_idx,
    .sw_count, .sw_rec_addr, .sw_rec_data, .sw_rec_flags, .irq
  );

  // Expected state of each log.
  logic [15:0] ma [2][8];
  logic [31:0] md [2][8];
  logic [1:0]  mf [2][8];
  int          mc [2];
  bit          mirq [2];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic verify_logs();
    for (int l = 0; l < 2; l++) begin
      sw_log_sel = 1'(l);
      sw_rd_idx  = 2'd0;
      #0.1;
      chk(sw_count == 3'(mc[l]), "R6/R7 log count", 64'(sw_count), 64'(mc[l]));
      chk(irq[l] == mirq[l], "R9 irq level", 64'(irq[l]), 64'(mirq[l]));
      for (int k = 0; k < mc[l]; k++) begin
        sw_rd_idx = 2'(k);
        #0.1;
        chk(sw_rec_addr == ma[l][k], "R3/R7 record address", 64'(sw_rec_addr), 64'(ma[l][k]));
        chk(sw_rec_data == md[l][k], "R4/R5 record data", 64'(sw_rec_data), 64'(md[l][k]));
        chk(sw_rec_flags == mf[l][k], "R3/R5 record flags", 64'(sw_rec_flags), 64'(mf[l][k]));
      end
    end
  endtask

  task automatic send(input bit wr, input logic [7:0] pg, input logic [7:0] off,
                      input logic [31:0] d);
    bit rec, keep, ewe, ere;
    logic [1:0] ecode;
    int l;
    rec = 0; keep = 0; ewe = 0; ere = 0; ecode = 2'd0;
    l = int'(pg[5]);
    if (wr) begin
      if (pg[0]) ewe = 1;
      else if (pg[1]) begin rec = 1; keep = pg[2]; ecode = 2'd1; end
      else ecode = 2'd2;
    end else begin
      ere = 1;
      if (pg[3]) begin rec = 1; keep = pg[4]; ecode = 2'd3; end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {pg, off}; req_data = d;
    #0.5;
    chk(req_ready == 1'b1, "R8 ready when room", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(cpl_valid == 1'b1, "R1 completion strobe", 64'(cpl_valid), 64'd1);
    chk(cpl_code == ecode, "R1/R2/R3/R5 completion code", 64'(cpl_code), 64'(ecode));
    chk(cpl_addr == {pg, off}, "R1 completion address", 64'(cpl_addr), 64'({pg, off}));
    chk(mem_we == ewe, "R1/R2 memory write strobe", 64'(mem_we), 64'(ewe));
    chk(mem_re == ere, "R5 memory read strobe", 64'(mem_re), 64'(ere));
    if (ewe) chk(mem_wdata == d, "R1 memory write data", 64'(mem_wdata), 64'(d));
    if (rec) begin
      ma[l][mc[l]] = {pg, off};
      md[l][mc[l]] = keep ? d : 32'd0;
      mf[l][mc[l]] = {~wr, keep};
      mc[l]++;
      mirq[l] = 1;
    end
    verify_logs();
  endtask

  task automatic pop(input int l);
    @(negedge clk);
    sw_log_sel = 1'(l); sw_pop = 1'b1;
    @(negedge clk);
    sw_pop = 1'b0;
    if (mc[l] > 0) begin
      for (int k = 0; k < 7; k++) begin
        ma[l][k] = ma[l][k+1]; md[l][k] = md[l][k+1]; mf[l][k] = mf[l][k+1];
      end
      mc[l]--;
      mirq[l] = 0;
    end
    verify_logs();
  endtask

  task automatic t_reset();
    verify_logs();
    chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
    chk(cpl_valid == 1'b0, "R10 no completion after reset", 64'(cpl_valid), 64'd0);
    chk(irq == 2'b00, "R10 irq after reset", 64'(irq), 64'd0);
  endtask

  task automatic t_write_combos();
    for (int p = 0; p < 8; p++) send(1'b1, 8'(p), 8'(16 + p), 32'hA500_0000 + 32'(p));
    chk(irq == 2'b01, "R6 only log 0 interrupted", 64'(irq), 64'd1);
    pop(0);
    pop(0);
  endtask

  task automatic t_read_combos();
    send(1'b0, 8'd0,  8'h11, 32'h1111_0000);
    send(1'b0, 8'd8,  8'h22, 32'h2222_0000);
    send(1'b0, 8'd24, 8'h33, 32'h3333_0000);
    send(1'b0, 8'd1,  8'h44, 32'h4444_0000);
    pop(0);
    pop(0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++) send(1'b1, 8'd34, 8'(i), 32'hB000_0000 + 32'(i));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {8'd38, 8'h55}; req_data = 32'hDEAD_0004;
    #0.5;
    chk(req_ready == 1'b0, "R8 stall on full log", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(cpl_valid == 1'b0, "R8 no completion while stalled", 64'(cpl_valid), 64'd0);
    chk(req_ready == 1'b0, "R8 still stalled", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    verify_logs();
    send(1'b1, 8'd33, 8'h66, 32'hC0DE_0001);
    send(1'b1, 8'd2, 8'h77, 32'hC0DE_0002);
    pop(1);
    send(1'b1, 8'd38, 8'h55, 32'hDEAD_0004);
    pop(0);
    for (int i = 0; i < 4; i++) pop(1);
  endtask

  task automatic t_pop_empty();
    pop(1);
    pop(0);
    chk(irq == 2'b00, "R10 pop on empty leaves irq low", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_data = '0;
    sw_pop = 1'b0; sw_log_sel = '0; sw_rd_idx = '0;
    mc[0] = 0; mc[1] = 0; mirq[0] = 0; mirq[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_combos();
    t_read_combos();
    t_overflow();
    t_pop_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule